// File: doc/BRIEF.md
# Flash Program/Erase Gate Registers

This block is a small register bank in front of an embedded flash array. Software uses it to move the array into a program or erase state. The bank holds a write-enable control, a program setup bit and an erase setup bit, a program execute bit and an erase execute bit, a sticky error flag, and a one-hot selection of which of up to sixteen erase blocks is targeted. Every register output goes straight to the flash macro as a level strobe.

The bank enforces a fixed order. Nothing happens unless write-enable is 1. A setup bit must already be 1 before its execute bit will take. Only one kind of setup can be active at a time. The block selection can never name more than one block. Inputs for hardware standby, power mode and error pulses clear the bank, or part of it, on the next clock edge without any software action.

The register port has a 2-bit address, 8-bit write data with a write strobe, and combinational 8-bit read data. Address 0 is the control register: bit 7 is write-enable, bit 1 is erase execute and bit 0 is program execute. Address 1 is the setup/status register: bit 7 is the error flag, bits 6 to 2 are unused, bit 1 is erase setup and bit 0 is program setup. Address 2 selects blocks 0 to 7 and address 3 selects blocks 8 to 15, where bit n of a byte is block (byte×8+n).

Top module: `flash_pe_regs`

## Requirements
- R1: While reset (rstN low) or hwStandby is 1, every register clears, including the error flag. After either, all four addresses read 0x00 and every strobe output is 0.
- R2: At address 1, bit 7 is the error flag and cannot be written. Bits 6 to 2 always read 0, and any value written to them has no effect.
- R3: A write to address 1 changes the setup bits only when write-enable (address 0, bit 7) is already 1. Otherwise both setup bits stay 0.
- R4: Program setup (bit 0) and erase setup (bit 1) are mutually exclusive. A setup write is ignored if it sets both bits, or if it sets one bit while the other is already 1.
- R5: A write to address 0 sets an execute bit only if its matching setup bit is already 1 and the error flag is 0. Otherwise that execute bit is 0 after the write.
- R6: Clearing a setup bit also clears its execute bit in the same cycle.
- R7: Clearing write-enable clears both setup bits, both execute bits and the whole block selection.
- R8: pwrMode codes are 0 active, 1 software standby, 2 sub-active, 3 sub-sleep and 4 watch. In modes 1 to 4 the setup and execute bits clear. In modes 1 to 3 the block selection also clears, but in watch mode it is kept.
- R9: A write to address 2 or 3 that would leave more than one selection bit set across both bytes clears both bytes. A write that leaves at most one bit set is stored.
- R10: Writes to addresses 2 and 3 are ignored while write-enable is 0.
- R11: A one-cycle errPulse sets the error flag. The flag stays set until reset or hwStandby. While it is set, both execute outputs are 0 and execute writes do not take.
- R12: regRdata shows the addressed register in the same cycle. The strobe outputs follow the register bits one clock after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hwStandby | input | 1 | Hardware standby; clears the whole bank |
| pwrMode | input | 3 | Current power mode code |
| errPulse | input | 1 | One-cycle error event from the flash sequencer |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Combinational read data |
| progSetupOut | output | 1 | Program setup strobe |
| eraseSetupOut | output | 1 | Erase setup strobe |
| progExecOut | output | 1 | Program execute strobe |
| eraseExecOut | output | 1 | Erase execute strobe |
| blockSelOut | output | 16 | One-hot erase block selection |

## Verification
The bench targets the ordering rules:
- An execute write with no setup in place. A design that skips this check would drive the array with no setup time.
- A setup write that crosses over to the other setup kind. A design that allows it would show both setup strobes at once.
- Two selection bits spread across the two bytes. A design that checks only one byte would hold two blocks selected.

It also targets the clears:
- Watch mode must keep the block selection while the other low-power modes drop it. A design that merges the modes would lose or keep the wrong state.
- The error flag must survive clearing write-enable and must still block execute writes. A design that got this wrong would let the array run again after an error.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [2:0] {
    PWR_ACTIVE    = 3'd0,
    PWR_SW_STBY   = 3'd1,
    PWR_SUB_ACT   = 3'd2,
    PWR_SUB_SLEEP = 3'd3,
    PWR_WATCH     = 3'd4
  } pwr_e;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SETUP = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEL0  = 2'd2;

  // strobes from control decode to register datapath
  typedef struct packed {
    logic hardClr;
    logic clrSetup;
    logic clrSel;
    logic wrCtrl;
    logic wrSetup;
    logic wrSel;
  } strobe_t;
endpackage

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
(
  input  logic              hwStandby,
  input  logic [2:0]        pwrMode,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);
  pwr_e mode;

  always_comb begin
    mode = pwr_e'(pwrMode);
    stb = '0;
    stb.hardClr = hwStandby;
    unique case (mode)
      PWR_SW_STBY, PWR_SUB_ACT, PWR_SUB_SLEEP: begin
        stb.clrSetup = 1'b1;
        stb.clrSel   = 1'b1;
      end
      PWR_WATCH: stb.clrSetup = 1'b1;
      default: ;
    endcase
    stb.wrCtrl  = regWr && (regAddr == ADDR_CTRL);
    stb.wrSetup = regWr && (regAddr == ADDR_SETUP);
    stb.wrSel   = regWr && (regAddr >= ADDR_SEL0);
  end
endmodule

// File: rtl/flash_pe_datapath.sv
module flash_pe_datapath
  import flash_pe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_BLOCKS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic                  errPulse,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  output logic                  progSetupOut,
  output logic                  eraseSetupOut,
  output logic                  progExecOut,
  output logic                  eraseExecOut,
  output logic [NUM_BLOCKS-1:0] blockSelOut
);
  localparam int SEL_BYTES = NUM_BLOCKS / DATA_W;
  localparam int TOP_BIT   = DATA_W - 1;

  logic wrEnQ, progSetQ, eraseSetQ, progGoQ, eraseGoQ, errQ;
  logic wrEnD, progSetD, eraseSetD, progGoD, eraseGoD, errD;
  logic [NUM_BLOCKS-1:0] selQ, selD, selCand;
  logic [ADDR_W-1:0] selIdx;
  logic setupLegal;

  assign selIdx = regAddr - ADDR_SEL0;

  always_comb begin
    selCand = selQ;
    for (int b = 0; b < SEL_BYTES; b++)
      if (selIdx == ADDR_W'(b)) selCand[b*DATA_W +: DATA_W] = regWdata;
  end

  assign setupLegal = !(regWdata[1] && regWdata[0]) &&
                      !(regWdata[0] && eraseSetQ) &&
                      !(regWdata[1] && progSetQ);

  always_comb begin
    wrEnD = wrEnQ; progSetD = progSetQ; eraseSetD = eraseSetQ;
    progGoD = progGoQ; eraseGoD = eraseGoQ; selD = selQ;
    errD = errQ | errPulse;
    if (stb.wrCtrl) begin
      wrEnD    = regWdata[TOP_BIT];
      progGoD  = regWdata[0] && progSetQ && !errQ;
      eraseGoD = regWdata[1] && eraseSetQ && !errQ;
    end
    if (stb.wrSetup && wrEnQ && setupLegal) begin
      progSetD  = regWdata[0];
      eraseSetD = regWdata[1];
    end
    if (stb.wrSel && wrEnQ)
      selD = ($countones(selCand) > 1) ? '0 : selCand;
    if (!wrEnD || stb.clrSetup) begin
      progSetD = 1'b0; eraseSetD = 1'b0;
    end
    if (!wrEnD || stb.clrSel) selD = '0;
    if (!progSetD || errD)  progGoD  = 1'b0;
    if (!eraseSetD || errD) eraseGoD = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEnQ <= 1'b0; progSetQ <= 1'b0; eraseSetQ <= 1'b0;
      progGoQ <= 1'b0; eraseGoQ <= 1'b0; errQ <= 1'b0; selQ <= '0;
    end else if (stb.hardClr) begin
      wrEnQ <= 1'b0; progSetQ <= 1'b0; eraseSetQ <= 1'b0;
      progGoQ <= 1'b0; eraseGoQ <= 1'b0; errQ <= 1'b0; selQ <= '0;
    end else begin
      wrEnQ <= wrEnD; progSetQ <= progSetD; eraseSetQ <= eraseSetD;
      progGoQ <= progGoD; eraseGoQ <= eraseGoD; errQ <= errD; selQ <= selD;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CTRL) begin
      regRdata[TOP_BIT] = wrEnQ;
      regRdata[1:0] = {eraseGoQ, progGoQ};
    end else if (regAddr == ADDR_SETUP) begin
      regRdata[TOP_BIT] = errQ;
      regRdata[1:0] = {eraseSetQ, progSetQ};
    end else begin
      for (int b = 0; b < SEL_BYTES; b++)
        if (selIdx == ADDR_W'(b)) regRdata = selQ[b*DATA_W +: DATA_W];
    end
  end

  assign progSetupOut  = progSetQ;
  assign eraseSetupOut = eraseSetQ;
  assign progExecOut   = progGoQ;
  assign eraseExecOut  = eraseGoQ;
  assign blockSelOut   = selQ;

  // R4
  setup_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progSetQ, eraseSetQ}));
  // R5
  exec_needs_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progGoQ |-> progSetQ) and (eraseGoQ |-> eraseSetQ));
  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selQ));
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(errQ) && !$past(stb.hardClr) |-> errQ);
  // R11
  err_exec_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> !(progGoQ || eraseGoQ));
  // R7
  wren_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEnQ |-> (selQ == '0) && !progSetQ && !eraseSetQ);
endmodule

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
  import flash_pe_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_BLOCKS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hwStandby,
  input  logic [2:0]            pwrMode,
  input  logic                  errPulse,
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  output logic                  progSetupOut,
  output logic                  eraseSetupOut,
  output logic                  progExecOut,
  output logic                  eraseExecOut,
  output logic [NUM_BLOCKS-1:0] blockSelOut
);
  strobe_t stb;

  flash_pe_ctrl u_ctrl (
    .hwStandby(hwStandby), .pwrMode(pwrMode), .regWr(regWr),
    .regAddr(regAddr), .stb(stb)
  );

  flash_pe_datapath #(.DATA_W(DATA_W), .NUM_BLOCKS(NUM_BLOCKS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .errPulse(errPulse),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .progSetupOut(progSetupOut), .eraseSetupOut(eraseSetupOut),
    .progExecOut(progExecOut), .eraseExecOut(eraseExecOut),
    .blockSelOut(blockSelOut)
  );
endmodule

// File: tb/flash_pe_regs_tb.sv
module flash_pe_regs_tb;
  localparam int CLK_NS = 20;
  localparam int NVEC = 18;
  // {req[3:0], wr, waddr[1:0], wdata[7:0], raddr[1:0], exp[7:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {4'd3,  1'b1, 2'd1, 8'h01, 2'd1, 8'h00}, // R3 setup with write-enable off
    {4'd12, 1'b1, 2'd0, 8'h80, 2'd0, 8'h80}, // R12 enable readback
    {4'd5,  1'b1, 2'd0, 8'h81, 2'd0, 8'h80}, // R5 exec without setup
    {4'd3,  1'b1, 2'd1, 8'h01, 2'd1, 8'h01}, // R3 program setup
    {4'd4,  1'b1, 2'd1, 8'h02, 2'd1, 8'h01}, // R4 cross to erase ignored
    {4'd2,  1'b1, 2'd1, 8'hFD, 2'd1, 8'h01}, // R2 reserved/flag unwritable
    {4'd5,  1'b1, 2'd0, 8'h81, 2'd0, 8'h81}, // R5 program exec
    {4'd6,  1'b1, 2'd1, 8'h00, 2'd0, 8'h80}, // R6 setup clear drops exec
    {4'd4,  1'b1, 2'd1, 8'h03, 2'd1, 8'h00}, // R4 both setups ignored
    {4'd4,  1'b1, 2'd1, 8'h02, 2'd1, 8'h02}, // R4 erase setup
    {4'd5,  1'b1, 2'd0, 8'h82, 2'd0, 8'h82}, // R5 erase exec
    {4'd9,  1'b1, 2'd2, 8'h04, 2'd2, 8'h04}, // R9 block 2
    {4'd9,  1'b1, 2'd3, 8'h10, 2'd2, 8'h00}, // R9 cross-byte double clears
    {4'd9,  1'b1, 2'd3, 8'h10, 2'd3, 8'h10}, // R9 block 12
    {4'd9,  1'b1, 2'd3, 8'h30, 2'd3, 8'h00}, // R9 two bits in one byte
    {4'd9,  1'b1, 2'd2, 8'h80, 2'd2, 8'h80}, // R9 block 7
    {4'd7,  1'b1, 2'd0, 8'h00, 2'd2, 8'h00}, // R7 enable off clears select
    {4'd10, 1'b1, 2'd2, 8'h01, 2'd2, 8'h00}  // R10 select write ignored
  };

  logic clk = 1'b0, rstN = 1'b0, hwStandby = 1'b0, errPulse = 1'b0, regWr = 1'b0;
  logic [2:0] pwrMode = 3'd0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic progSetupOut, eraseSetupOut, progExecOut, eraseExecOut;
  logic [15:0] blockSelOut;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  flash_pe_regs u_dut (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .pwrMode(pwrMode),
    .errPulse(errPulse), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .progSetupOut(progSetupOut), .eraseSetupOut(eraseSetupOut),
    .progExecOut(progExecOut), .eraseExecOut(eraseExecOut), .blockSelOut(blockSelOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a; #1;
    check(req, 32'(regRdata), 32'(exp));
  endtask

  task automatic holdPwr(input logic [2:0] m);
    @(negedge clk); pwrMode = m;
    @(negedge clk); pwrMode = 3'd0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) rdCheck("R1 reset read", 2'(a), 8'h00);
    check("R1 reset strobes", {28'd0, progSetupOut, eraseSetupOut, progExecOut, eraseExecOut}, 32'd0);
    check("R1 reset select", 32'(blockSelOut), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] v;
      v = VEC[i];
      if (v[20]) wrReg(v[19:18], v[17:10]);
      regAddr = v[9:8]; #1;
      checks++;
      if (regRdata !== v[7:0]) begin
        failures++;
        $display("FAIL R%0d vector %0d actual=%0h expected=%0h", v[24:21], i, regRdata, v[7:0]);
      end
    end

    // R12 strobe outputs follow registers
    wrReg(2'd0, 8'h80); wrReg(2'd1, 8'h01); wrReg(2'd0, 8'h81);
    check("R12 prog exec strobe", {30'd0, progSetupOut, progExecOut}, 32'd3);
    check("R12 erase strobes", {30'd0, eraseSetupOut, eraseExecOut}, 32'd0);

    // R8 watch keeps selection, clears setup and exec
    wrReg(2'd2, 8'h08);
    holdPwr(3'd4);
    check("R8 watch setup", {29'd0, progSetupOut, progExecOut, eraseSetupOut}, 32'd0);
    check("R8 watch keeps select", 32'(blockSelOut), 32'h0008);
    wrReg(2'd1, 8'h02);
    holdPwr(3'd3);
    check("R8 sub-sleep clears", {15'd0, eraseSetupOut, blockSelOut}, 32'd0);
    wrReg(2'd3, 8'h01);
    holdPwr(3'd1);
    check("R8 sw standby clears select", 32'(blockSelOut), 32'd0);

    // R11 error flag
    wrReg(2'd1, 8'h01); wrReg(2'd0, 8'h81);
    @(negedge clk); errPulse = 1'b1;
    @(negedge clk); errPulse = 1'b0;
    check("R11 exec forced off", {31'd0, progExecOut}, 32'd0);
    rdCheck("R11 flag set", 2'd1, 8'h81);
    wrReg(2'd0, 8'h81);
    rdCheck("R11 exec write blocked", 2'd0, 8'h80);
    wrReg(2'd0, 8'h00); wrReg(2'd0, 8'h80);
    rdCheck("R11 flag sticky", 2'd1, 8'h80);
    wrReg(2'd1, 8'h00);
    rdCheck("R2 flag not writable", 2'd1, 8'h80);

    // R1 hardware standby clears all
    @(negedge clk); hwStandby = 1'b1;
    @(negedge clk); hwStandby = 1'b0;
    rdCheck("R1 standby status", 2'd1, 8'h00);
    rdCheck("R1 standby ctrl", 2'd0, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule